// File: doc/BRIEF.md
# Isolated I/O Port Decoder

This block sits on a 16-bit data bus, beside a separate I/O address space that has its own read and write strobes. It decodes port numbers for three devices. The first is an 8-bit input device at a short (8-bit) port number. The second is an 8-bit input device at a full 16-bit port number. The third is an 8-bit output register at a short port number. It also decodes a group of eight consecutive short port numbers into one-of-eight selects, active low, for further devices.

Even and odd port numbers sit on different byte lanes of the data bus. The even lane is bits 7..0 and the odd lane is bits 15..8. All reads share one read strobe, because the processor simply ignores the byte lane it did not ask for. Writes use a separate strobe for each lane. The even-lane strobe is qualified by address bit 0 being low. The odd-lane strobe is qualified by the active-low bus-high enable. The output register captures its data when its decoded write strobe ends. The capture is taken on the first system clock edge after that point.

Top module: `io_port_decoder`

## Requirements
- R1: A short port number matches only when address bits 15..8 are 00h and bits 7..0 equal the port number. For example, 018Fh matches no port and gives no read drive.
- R2: The 16-bit input port at FFF0h matches only on the full address FFF0h. It returns its byte on data bits 7..0, with bits 15..8 at zero.
- R3: The short input port at 8Fh is odd, so its byte appears on data bits 15..8, with bits 7..0 at zero. The read enable is 1 only while the read strobe (active low) is low and the address is 008Fh.
- R4: When the read strobe is high, or no input port matches, the read enable is 0 and the read data is 0000h.
- R5: The output port at F0h is even. A write to address 00F0h captures data bits 7..0. The new value appears after the first clock edge at which the write strobe is high again, and it is held until the next write to that port.
- R6: A write to 00F1h or to 01F0h leaves the output register unchanged. The bus-high enable has no effect on a write to 00F0h, and data bits 15..8 are never captured.
- R7: Read cycles at any address leave the output register unchanged.
- R8: The group select output is 8 bits and active low. For an address in 0088h..008Fh, exactly bit (address bits 2..0) is 0. For any other address, all bits are 1. This output does not depend on either strobe.
- R9: After reset the output register holds 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 16 | I/O port address |
| io_rd_n | input | 1 | I/O read strobe, active low |
| io_wr_n | input | 1 | I/O write strobe, active low |
| bus_hi_en_n | input | 1 | Odd byte lane enable, active low |
| data_in | input | 16 | Write data from the bus |
| sw_in | input | 8 | Value of the input device at short port 8Fh |
| wide_in | input | 8 | Value of the input device at port FFF0h |
| rd_data | output | 16 | Read data placed on the addressed lane |
| rd_drive | output | 1 | Read data drive enable |
| led_out | output | 8 | Held output-port value |
| grp_sel_n | output | 8 | One-of-eight selects for ports 88h..8Fh, active low |

## Verification
The only state in the block is the output register and its capture stage. A wrong capture value or a missed disarm shows on led_out one clock edge after the write strobe rises. A spurious load shows on led_out at the first clock edge after any unrelated cycle. Because of this, every write check samples the output both before and after that edge. Decode and lane placement are purely combinational, so an error there shows on rd_data, rd_drive or grp_sel_n in the same cycle as the address that triggers it.

// File: rtl/io_port_pkg.sv
package io_port_pkg;
  localparam int unsigned IO_AW  = 16;
  localparam int unsigned LANE_W = 8;

  // short port: upper byte zero, low byte equals the port number
  function automatic logic short_hit(input logic [IO_AW-1:0] a,
                                     input logic [LANE_W-1:0] port);
    return (a[IO_AW-1:LANE_W] == '0) && (a[LANE_W-1:0] == port);
  endfunction

  // place a byte on the lane picked by the port's bit 0
  function automatic logic [IO_AW-1:0] lane_place(input logic odd,
                                                  input logic [LANE_W-1:0] b);
    return odd ? {b, {LANE_W{1'b0}}} : {{LANE_W{1'b0}}, b};
  endfunction

  // pick the byte of the write data that belongs to a lane
  function automatic logic [LANE_W-1:0] lane_pick(input logic odd,
                                                  input logic [IO_AW-1:0] d);
    return odd ? d[IO_AW-1:LANE_W] : d[LANE_W-1:0];
  endfunction
endpackage

// File: rtl/io_addr_match.sv
module io_addr_match
  import io_port_pkg::*;
#(
  parameter logic [LANE_W-1:0] IN_PORT   = 8'h8F,
  parameter logic [IO_AW-1:0]  WIDE_PORT = 16'hFFF0,
  parameter logic [LANE_W-1:0] OUT_PORT  = 8'hF0
) (
  input  logic [IO_AW-1:0] addr,
  input  logic             wr_n,
  input  logic             bhe_n,
  output logic             in_hit,
  output logic             wide_hit,
  output logic             wr_lo,
  output logic             wr_hi,
  output logic             out_wr
);
  assign in_hit   = short_hit(addr, IN_PORT);
  assign wide_hit = (addr == WIDE_PORT);
  // per-lane write strobes
  assign wr_lo    = ~wr_n & ~addr[0];
  assign wr_hi    = ~wr_n & ~bhe_n;
  assign out_wr   = short_hit(addr, OUT_PORT) & (OUT_PORT[0] ? wr_hi : wr_lo);
endmodule

// File: rtl/io_group_decode.sv
module io_group_decode
  import io_port_pkg::*;
#(
  parameter logic [LANE_W-1:0] GRP_BASE = 8'h88,
  parameter int unsigned       GRP_BITS = 3
) (
  input  logic [IO_AW-1:0]            addr,
  output logic [(1<<GRP_BITS)-1:0]    sel_n
);
  localparam int unsigned GRP_N = 1 << GRP_BITS;

  logic grp_en;
  assign grp_en = (addr[IO_AW-1:LANE_W] == '0) &&
                  (addr[LANE_W-1:GRP_BITS] == GRP_BASE[LANE_W-1:GRP_BITS]);

  for (genvar i = 0; i < GRP_N; i++) begin : g_sel
    assign sel_n[i] = ~(grp_en && (addr[GRP_BITS-1:0] == GRP_BITS'(i)));
  end
endmodule

// File: rtl/io_read_mux.sv
module io_read_mux
  import io_port_pkg::*;
#(
  parameter bit IN_ODD   = 1'b1,
  parameter bit WIDE_ODD = 1'b0
) (
  input  logic              rd_n,
  input  logic              in_hit,
  input  logic              wide_hit,
  input  logic [LANE_W-1:0] sw_val,
  input  logic [LANE_W-1:0] wide_val,
  output logic [IO_AW-1:0]  rd_data,
  output logic              rd_drive
);
  always_comb begin
    rd_drive = 1'b0;
    rd_data  = '0;
    if (!rd_n && in_hit) begin
      rd_drive = 1'b1;
      rd_data  = lane_place(IN_ODD, sw_val);
    end else if (!rd_n && wide_hit) begin
      rd_drive = 1'b1;
      rd_data  = lane_place(WIDE_ODD, wide_val);
    end
  end
endmodule

// File: rtl/io_out_latch.sv
module io_out_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         load
);
  logic [W-1:0] cap_q;
  logic         armed_q;

  // strobe has ended after having been seen active
  assign load = armed_q & ~wr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      armed_q <= 1'b0;
      q       <= '0;
    end else begin
      if (wr_hit) begin
        cap_q   <= din;
        armed_q <= 1'b1;
      end else begin
        armed_q <= 1'b0;
      end
      if (load) q <= cap_q;
    end
  end
endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
  import io_port_pkg::*;
#(
  parameter logic [7:0]  IN_PORT   = 8'h8F,
  parameter logic [15:0] WIDE_PORT = 16'hFFF0,
  parameter logic [7:0]  OUT_PORT  = 8'hF0,
  parameter logic [7:0]  GRP_BASE  = 8'h88,
  parameter int unsigned GRP_BITS  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_rd_n,
  input  logic        io_wr_n,
  input  logic        bus_hi_en_n,
  input  logic [15:0] data_in,
  input  logic [7:0]  sw_in,
  input  logic [7:0]  wide_in,
  output logic [15:0] rd_data,
  output logic        rd_drive,
  output logic [7:0]  led_out,
  output logic [7:0]  grp_sel_n
);
  // named internal events, used by the bound checker
  logic in_hit, wide_hit, wr_lo, wr_hi, out_wr, out_load;

  io_addr_match #(.IN_PORT(IN_PORT), .WIDE_PORT(WIDE_PORT), .OUT_PORT(OUT_PORT)) u_match (
    .addr(io_addr), .wr_n(io_wr_n), .bhe_n(bus_hi_en_n),
    .in_hit(in_hit), .wide_hit(wide_hit), .wr_lo(wr_lo), .wr_hi(wr_hi), .out_wr(out_wr)
  );

  io_read_mux #(.IN_ODD(IN_PORT[0]), .WIDE_ODD(WIDE_PORT[0])) u_rmux (
    .rd_n(io_rd_n), .in_hit(in_hit), .wide_hit(wide_hit),
    .sw_val(sw_in), .wide_val(wide_in), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  io_out_latch #(.W(LANE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_hit(out_wr),
    .din(lane_pick(OUT_PORT[0], data_in)), .q(led_out), .load(out_load)
  );

  io_group_decode #(.GRP_BASE(GRP_BASE), .GRP_BITS(GRP_BITS)) u_grp (
    .addr(io_addr), .sel_n(grp_sel_n)
  );
endmodule

// File: rtl/io_port_decoder_chk.sv
module io_port_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_rd_n,
  input logic [15:0] rd_data,
  input logic        rd_drive,
  input logic [7:0]  led_out,
  input logic [7:0]  grp_sel_n,
  input logic        out_load,
  input logic        wr_lo,
  input logic        wr_hi,
  input logic        out_wr
);
  // R3: drive only inside a read strobe
  a_r3_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive |-> !io_rd_n);

  // R4: undriven bus carries zero
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drive |-> (rd_data == 16'h0000));

  // R2/R3: one lane only per read
  a_r2_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive |-> (rd_data[15:8] == 8'h00 || rd_data[7:0] == 8'h00));

  // R8: at most one group select active
  a_r8_group_onecold: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~grp_sel_n));

  // R5/R7: the register moves only on a load event
  a_r5_hold_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    !out_load |=> $stable(led_out));

  // R6: port write requires a lane strobe
  a_r6_write_needs_lane: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> (wr_lo || wr_hi));
endmodule

bind io_port_decoder io_port_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_rd_n(io_rd_n), .rd_data(rd_data),
  .rd_drive(rd_drive), .led_out(led_out), .grp_sel_n(grp_sel_n),
  .out_load(out_load), .wr_lo(wr_lo), .wr_hi(wr_hi), .out_wr(out_wr)
);

// File: tb/io_port_decoder_test.sv
`timescale 1ns/1ps
module io_port_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_rd_n, io_wr_n, bus_hi_en_n;
  logic [15:0] data_in;
  logic [7:0]  sw_in, wide_in;
  logic [15:0] rd_data;
  logic        rd_drive;
  logic [7:0]  led_out, grp_sel_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  io_port_decoder uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd_n(io_rd_n),
    .io_wr_n(io_wr_n), .bus_hi_en_n(bus_hi_en_n), .data_in(data_in),
    .sw_in(sw_in), .wide_in(wide_in), .rd_data(rd_data), .rd_drive(rd_drive),
    .led_out(led_out), .grp_sel_n(grp_sel_n)
  );

  // expected read result {drive, data}
  function automatic logic [16:0] exp_read(input logic [15:0] a, input logic rn,
                                           input logic [7:0] sw, input logic [7:0] wd);
    if (rn) return 17'h0;
    if (a == 16'h008F) return {1'b1, sw, 8'h00};
    if (a == 16'hFFF0) return {1'b1, 8'h00, wd};
    return 17'h0;
  endfunction

  function automatic logic [7:0] exp_grp(input logic [15:0] a);
    if (a >= 16'h0088 && a <= 16'h008F) return ~(8'h01 << (a - 16'h0088));
    return 8'hFF;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d,
                          input logic bhe, input int hold);
    @(negedge clk);
    io_addr = a; data_in = d; bus_hi_en_n = bhe; io_wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    io_wr_n = 1'b1;
  endtask

  // write, then check old value before the capture edge and the new value after
  task automatic write_check(input logic [15:0] a, input logic [15:0] d,
                             input logic bhe, input int hold,
                             input logic [7:0] old_v, input logic [7:0] new_v,
                             input string req);
    do_write(a, d, bhe, hold);
    #1 chk(led_out == old_v, req, led_out, old_v);
    @(negedge clk);
    #1 chk(led_out == new_v, req, led_out, new_v);
  endtask

  task automatic read_check(input logic [15:0] a, input string req);
    logic [16:0] e;
    @(negedge clk);
    io_addr = a; io_rd_n = 1'b0;
    #1 e = exp_read(a, 1'b0, sw_in, wide_in);
    chk({rd_drive, rd_data} == e, req, {rd_drive, rd_data}, e);
    io_rd_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] led_model;
    void'($urandom(32'd2024));
    rst_n = 1'b0; io_addr = 16'h0000; io_rd_n = 1'b1; io_wr_n = 1'b1;
    bus_hi_en_n = 1'b1; data_in = 16'h0000; sw_in = 8'hC3; wide_in = 8'h5E;
    repeat (3) @(negedge clk);
    #1 chk(led_out == 8'h00, "R9", led_out, 8'h00);
    chk(rd_drive == 1'b0, "R4", rd_drive, 0);
    rst_n = 1'b1;

    // directed reads
    read_check(16'h008F, "R3");
    read_check(16'h018F, "R1");
    read_check(16'hFFF0, "R2");
    read_check(16'h00F0, "R4");
    @(negedge clk); io_addr = 16'h008F; io_rd_n = 1'b1;
    #1 chk(rd_drive == 1'b0 && rd_data == 16'h0, "R4", {rd_drive, rd_data}, 0);
    io_addr = 16'h008A; io_wr_n = 1'b0;
    #1 chk(grp_sel_n == 8'hFB, "R8", grp_sel_n, 8'hFB);
    io_wr_n = 1'b1; io_addr = 16'h0090;
    #1 chk(grp_sel_n == 8'hFF, "R8", grp_sel_n, 8'hFF);

    // directed writes
    write_check(16'h00F0, 16'hEEA5, 1'b1, 1, 8'h00, 8'hA5, "R5");
    write_check(16'h00F1, 16'h3C3C, 1'b0, 2, 8'hA5, 8'hA5, "R6");
    write_check(16'h01F0, 16'h1111, 1'b1, 1, 8'hA5, 8'hA5, "R1");
    write_check(16'h00F0, 16'h5A77, 1'b0, 3, 8'hA5, 8'h77, "R6");
    repeat (4) @(negedge clk);
    #1 chk(led_out == 8'h77, "R5", led_out, 8'h77);
    led_model = 8'h77;

    // random reads and group decodes
    for (int i = 0; i < 400; i++) begin
      logic [16:0] e;
      logic [7:0]  g;
      @(negedge clk);
      case ($urandom % 8)
        0: io_addr = 16'h008F;
        1: io_addr = 16'hFFF0;
        2: io_addr = 16'h0088 + 16'($urandom % 8);
        3: io_addr = 16'h00F0;
        4: io_addr = {8'($urandom % 255 + 1), 8'h8F};
        5: io_addr = 16'h0080 + 16'($urandom % 32);
        default: io_addr = 16'($urandom);
      endcase
      io_rd_n = 1'($urandom); bus_hi_en_n = 1'($urandom);
      data_in = 16'($urandom); sw_in = 8'($urandom); wide_in = 8'($urandom);
      #1 e = exp_read(io_addr, io_rd_n, sw_in, wide_in);
      g = exp_grp(io_addr);
      chk({rd_drive, rd_data} == e, "R3", {rd_drive, rd_data}, e);
      chk(grp_sel_n == g, "R8", grp_sel_n, g);
    end
    @(negedge clk); io_rd_n = 1'b1;
    @(negedge clk);
    #1 chk(led_out == led_model, "R7", led_out, led_model);

    // reset returns the register to zero
    rst_n = 1'b0;
    @(negedge clk);
    #1 chk(led_out == 8'h00, "R9", led_out, 8'h00);
    rst_n = 1'b1;
    write_check(16'h00F0, 16'h0042, 1'b1, 2, 8'h00, 8'h42, "R5");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule